// File: doc/BRIEF.md
# Open-Row SDRAM Read Command Sequencer

This block converts read requests into SDRAM command cycles. A request carries a bank, a row, a column and a word count. For each of four banks the block remembers whether a row is open and which row it is. A request that lands on the open row of its bank goes straight to a READ. Any other request first closes the bank with PRECHARGE, then opens the wanted row with ACTIVATE, and only then issues READ. The idle gap after PRECHARGE and the gap after ACTIVATE are both set by configuration inputs.

The device always bursts eight words per READ. When fewer words are wanted, the block cuts the burst short with BURST STOP. It then waits out the CAS latency, which is 2 or 3 clocks, captures the wanted words from the data bus and presents them on a valid-qualified output. Only one request is in flight at a time, so the request port stays not-ready until the last word has been delivered.

Top module: `sdram_rd_seq`

## Requirements
- R1: Reset leaves every bank without an open row, so the first request to any bank takes the miss path. It also drives NOP, raises req_ready and clears rd_valid.
- R2: Commands are encoded on {sd_ras_n, sd_cas_n, sd_we_n} as NOP=111, ACTIVATE=011, READ=101, PRECHARGE=010 and BURST STOP=110. NOP is driven on every cycle without a command, and with it sd_ba=0 and sd_addr=0.
- R3: When the requested bank holds the requested row open, READ appears in the cycle after acceptance with sd_ba equal to the bank and sd_addr equal to the column. No PRECHARGE or ACTIVATE is issued.
- R4: When the bank has no open row, or has a different row open, the cycle after acceptance carries PRECHARGE (sd_ba=bank, sd_addr=0). ACTIVATE (sd_addr=row) follows trp+1 cycles later, and READ (sd_addr=column) follows trcd+1 cycles after the ACTIVATE.
- R5: PRECHARGE closes the record of its bank and ACTIVATE opens it with the new row. Records of different banks do not disturb one another.
- R6: With READ in cycle r and latency L (L=2 when cfg_cl is 2, otherwise L=3), the word on sd_dq in cycle r+L+i is presented on rd_data, with rd_valid high, in cycle r+L+i+1.
- R7: rd_valid is high for exactly N cycles per request, where N is req_len. A req_len of 0 or above 8 counts as 8.
- R8: When N is below 8, BURST STOP (sd_ba=bank, sd_addr=0) is issued in cycle r+N. When N is 8, no BURST STOP is issued.
- R9: req_ready is low from the cycle after acceptance and rises in the cycle that carries the last rd_valid.
- R10: cfg_trp, cfg_trcd, cfg_cl and req_len are sampled at acceptance. Later changes do not affect the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trp | input | 4 | Idle cycles between PRECHARGE and ACTIVATE |
| cfg_trcd | input | 4 | Idle cycles between ACTIVATE and READ |
| cfg_cl | input | 2 | CAS latency select (2, otherwise 3) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_bank | input | 2 | Requested bank |
| req_row | input | 13 | Requested row |
| req_col | input | 13 | Requested column |
| req_len | input | 4 | Words wanted (1 to 8) |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Row/column address |
| sd_dq | input | 16 | Read data from the device |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | 16 | Captured word |

## Verification
The bound checker watches every cycle for the following:
- every command word is legal and NOP carries a zero address;
- the cycle after a PRECHARGE or ACTIVATE stays NOP whenever the sampled gap is nonzero;
- READ only targets a bank whose row the command stream has opened, and ACTIVATE only targets a closed bank;
- BURST STOP appears only for short requests;
- req_ready stays low while commands are issued.

Which path a request takes, the exact cycle of each command, the data words with their latency and count, and the insensitivity to configuration changes while a request is in flight can only be shown by the bench. Its reference model compares the whole command trace and the data stream cycle by cycle across hit, bank-miss and row-miss cases.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_PRE = 3'b010,
    CMD_BST = 3'b110
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE_GAP,
    ST_ACT_GAP,
    ST_BURST
  } seq_state_e;

endpackage

// File: rtl/open_row_table.sv
module open_row_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_hit,
  input  logic              upd_en,
  input  logic              upd_open,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row
);
  localparam int NB = 1 << BANK_W;

  logic             vld_q [NB];
  logic [ROW_W-1:0] row_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[b] <= 1'b0;
      end else if (upd_en && upd_bank == BANK_W'(b)) begin
        vld_q[b] <= upd_open;
      end
    end

    always_ff @(posedge clk) begin
      if (upd_en && upd_open && upd_bank == BANK_W'(b)) begin
        row_q[b] <= upd_row;
      end
    end
  end

  assign lk_hit = vld_q[lk_bank] && (row_q[lk_bank] == lk_row);

endmodule

// File: rtl/rd_capture.sv
module rd_capture #(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/rd_cmd_fsm.sv
module rd_cmd_fsm
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int LEN_W     = 4,
  parameter int GAP_W     = 4,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GAP_W-1:0]  cfg_trp,
  input  logic [GAP_W-1:0]  cfg_trcd,
  input  logic [1:0]        cfg_cl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [ADDR_W-1:0] req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              hit,
  output logic              tbl_en,
  output logic              tbl_open,
  output logic [BANK_W-1:0] tbl_bank,
  output logic [ADDR_W-1:0] tbl_row,
  output sd_cmd_e           cmd_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cap_en
);
  localparam int CNT_W = $clog2(BURST_LEN + 4) + 1;

  seq_state_e        state_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic [CNT_W-1:0]  len_q, cl_q, cnt_q;
  logic [GAP_W-1:0]  trcd_q, gap_q;
  logic [CNT_W-1:0]  eff_len;
  logic              accept, issue_pre, issue_act;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign issue_pre = accept && !hit;
  assign issue_act = (state_q == ST_PRE_GAP) && (gap_q == '0);

  assign eff_len = (req_len == '0 || req_len > LEN_W'(BURST_LEN))
                   ? CNT_W'(BURST_LEN) : CNT_W'(req_len);

  assign tbl_en   = issue_pre || issue_act;
  assign tbl_open = issue_act;
  assign tbl_bank = issue_act ? bank_q : req_bank;
  assign tbl_row  = row_q;

  assign cap_en = (state_q == ST_BURST) && (cnt_q >= cl_q) && (cnt_q < cl_q + len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
      cl_q    <= '0;
      cnt_q   <= '0;
      trcd_q  <= '0;
      gap_q   <= '0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            bank_q <= req_bank;
            row_q  <= req_row;
            col_q  <= req_col;
            len_q  <= eff_len;
            cl_q   <= (cfg_cl == 2'd2) ? CNT_W'(2) : CNT_W'(3);
            trcd_q <= cfg_trcd;
            ba_q   <= req_bank;
            if (hit) begin
              cmd_q   <= CMD_RD;
              addr_q  <= req_col;
              cnt_q   <= '0;
              state_q <= ST_BURST;
            end else begin
              cmd_q   <= CMD_PRE;
              gap_q   <= cfg_trp;
              state_q <= ST_PRE_GAP;
            end
          end
        end
        ST_PRE_GAP: begin
          if (gap_q == '0) begin
            cmd_q   <= CMD_ACT;
            ba_q    <= bank_q;
            addr_q  <= row_q;
            gap_q   <= trcd_q;
            state_q <= ST_ACT_GAP;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        ST_ACT_GAP: begin
          if (gap_q == '0) begin
            cmd_q   <= CMD_RD;
            ba_q    <= bank_q;
            addr_q  <= col_q;
            cnt_q   <= '0;
            state_q <= ST_BURST;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        ST_BURST: begin
          cnt_q <= cnt_q + 1'b1;
          if (len_q < CNT_W'(BURST_LEN) && cnt_q == len_q - 1'b1) begin
            cmd_q <= CMD_BST;
            ba_q  <= bank_q;
          end
          if (cnt_q == cl_q + len_q - 1'b1) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int DQ_W      = 16,
  parameter int LEN_W     = 4,
  parameter int GAP_W     = 4,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GAP_W-1:0]  cfg_trp,
  input  logic [GAP_W-1:0]  cfg_trcd,
  input  logic [1:0]        cfg_cl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [ADDR_W-1:0] req_col,
  input  logic [LEN_W-1:0]  req_len,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  input  logic [DQ_W-1:0]   sd_dq,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data
);
  logic              hit, tbl_en, tbl_open, cap_en;
  logic [BANK_W-1:0] tbl_bank;
  logic [ADDR_W-1:0] tbl_row;
  sd_cmd_e           cmd;

  open_row_table #(.BANK_W(BANK_W), .ROW_W(ADDR_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .lk_bank  (req_bank),
    .lk_row   (req_row),
    .lk_hit   (hit),
    .upd_en   (tbl_en),
    .upd_open (tbl_open),
    .upd_bank (tbl_bank),
    .upd_row  (tbl_row)
  );

  rd_cmd_fsm #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .GAP_W(GAP_W), .BURST_LEN(BURST_LEN)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cfg_trp   (cfg_trp),
    .cfg_trcd  (cfg_trcd),
    .cfg_cl    (cfg_cl),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_len   (req_len),
    .hit       (hit),
    .tbl_en    (tbl_en),
    .tbl_open  (tbl_open),
    .tbl_bank  (tbl_bank),
    .tbl_row   (tbl_row),
    .cmd_q     (cmd),
    .ba_q      (sd_ba),
    .addr_q    (sd_addr),
    .cap_en    (cap_en)
  );

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  rd_capture #(.DQ_W(DQ_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .dq_in    (sd_dq),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/sdram_rd_seq_chk.sv
module sdram_rd_seq_chk #(
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int LEN_W     = 4,
  parameter int GAP_W     = 4,
  parameter int BURST_LEN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [GAP_W-1:0]  cfg_trp,
  input logic [GAP_W-1:0]  cfg_trcd,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BANK_W-1:0] sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              rd_valid
);
  localparam int NB = 1 << BANK_W;

  logic [2:0]      cmd;
  logic [NB-1:0]   open_q;
  logic [GAP_W-1:0] trp_q, trcd_q;
  logic            short_q;

  assign cmd = {sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= '0;
      trp_q   <= '0;
      trcd_q  <= '0;
      short_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        trp_q   <= cfg_trp;
        trcd_q  <= cfg_trcd;
        short_q <= (req_len != '0) && (req_len < LEN_W'(BURST_LEN));
      end
      if (cmd == 3'b011) open_q[sd_ba] <= 1'b1;
      if (cmd == 3'b010) open_q[sd_ba] <= 1'b0;
    end
  end

  p_legal_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    cmd inside {3'b111, 3'b011, 3'b101, 3'b010, 3'b110});
  p_nop_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b111) |-> (sd_ba == '0 && sd_addr == '0));
  p_trp_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b010 && trp_q != '0) |=> (cmd == 3'b111));
  p_trcd_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b011 && trcd_q != '0) |=> (cmd == 3'b111));
  p_read_open_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b101) |-> open_q[sd_ba]);
  p_act_closed_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b011) |-> !open_q[sd_ba]);
  p_bst_short_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b110) |-> short_q);
  p_busy_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd != 3'b111) |-> !req_ready);
  p_data_busy_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!req_ready));
endmodule

bind sdram_rd_seq sdram_rd_seq_chk #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
  .GAP_W(GAP_W), .BURST_LEN(BURST_LEN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_trp   (cfg_trp),
  .cfg_trcd  (cfg_trcd),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_len   (req_len),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_ba     (sd_ba),
  .sd_addr   (sd_addr),
  .rd_valid  (rd_valid)
);

// File: tb/test_sdram_rd_seq.sv
module test_sdram_rd_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_trp = '0, cfg_trcd = '0;
  logic [1:0]  cfg_cl = 2'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0, req_col = '0;
  logic [3:0]  req_len = '0;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq = '0;
  logic        rd_valid;
  logic [15:0] rd_data;

  sdram_rd_seq i_sdram_rd_seq (.*);

  always #2 clk = ~clk;

  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_tag = "";

  // reference model state
  bit        m_open [4];
  int        m_row  [4];
  int        e_cmd  [int];
  int        e_ba   [int];
  int        e_addr [int];
  string     e_ctag [int];
  int        e_dat  [int];
  string     e_dtag [int];
  int        ready_at = 0;

  function automatic logic [15:0] dqf(int c);
    return 16'((c * 40503) ^ 23130);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin #1; sd_dq = dqf(cyc); end

  always @(negedge clk) begin
    if (!rst && !done) begin
      int c, b, a, t, r, ln, cl;
      string tg;
      c  = e_cmd.exists(cyc)  ? e_cmd[cyc]  : 3'b111;
      b  = e_ba.exists(cyc)   ? e_ba[cyc]   : 0;
      a  = e_addr.exists(cyc) ? e_addr[cyc] : 0;
      tg = e_ctag.exists(cyc) ? e_ctag[cyc] : "R2";
      chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'(c), tg, "command", {sd_ras_n, sd_cas_n, sd_we_n}, c);
      chk(sd_ba == 2'(b), tg, "bank", sd_ba, b);
      chk(sd_addr == 13'(a), tg, "address", sd_addr, a);
      chk(req_ready == (cyc >= ready_at), "R9", "req_ready", req_ready, cyc >= ready_at);
      chk(rd_valid == e_dat.exists(cyc), "R7", "rd_valid", rd_valid, e_dat.exists(cyc));
      if (e_dat.exists(cyc) && rd_valid)
        chk(rd_data == 16'(e_dat[cyc]), e_dtag[cyc], "rd_data", rd_data, e_dat[cyc]);
      if (req_valid && req_ready) begin
        t  = cyc + 1;
        ln = (req_len == 0 || req_len > 8) ? 8 : int'(req_len);
        cl = (cfg_cl == 2'd2) ? 2 : 3;
        if (m_open[req_bank] && m_row[req_bank] == int'(req_row)) begin
          r = t;
          e_ctag[r] = {"R3 ", cur_tag};
        end else begin
          e_cmd[t] = 3'b010; e_ba[t] = req_bank; e_addr[t] = 0;
          e_ctag[t] = {"R4 ", cur_tag};
          t = t + int'(cfg_trp) + 1;
          e_cmd[t] = 3'b011; e_ba[t] = req_bank; e_addr[t] = req_row;
          e_ctag[t] = {"R4 ", cur_tag};
          r = t + int'(cfg_trcd) + 1;
          e_ctag[r] = {"R4 ", cur_tag};
          m_open[req_bank] = 1; m_row[req_bank] = req_row;
        end
        e_cmd[r] = 3'b101; e_ba[r] = req_bank; e_addr[r] = req_col;
        if (ln < 8) begin
          e_cmd[r+ln] = 3'b110; e_ba[r+ln] = req_bank; e_addr[r+ln] = 0;
          e_ctag[r+ln] = {"R8 ", cur_tag};
        end
        for (int i = 0; i < ln; i++) begin
          e_dat[r+cl+i+1]  = dqf(r + cl + i);
          e_dtag[r+cl+i+1] = {"R6 ", cur_tag};
        end
        ready_at = r + cl + ln;
      end
    end
  end

  task automatic send(int b, int row, int col, int len, int trp, int trcd, int cl, string tag);
    @(posedge clk); #1;
    req_bank = 2'(b); req_row = 13'(row); req_col = 13'(col); req_len = 4'(len);
    cfg_trp = 4'(trp); cfg_trcd = 4'(trcd); cfg_cl = 2'(cl);
    cur_tag = tag; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    // R10: disturb sampled inputs while the request is in flight
    cfg_trp = 4'(trp + 7); cfg_trcd = 4'(trcd + 5); cfg_cl = 2'(cl ^ 1); req_len = 4'(len + 3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "NOP after reset", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    send(0, 100, 8,  8, 2, 3, 3, "R1 closed bank");
    send(0, 100, 16, 4, 2, 3, 3, "R3 hit");
    send(0, 200, 24, 1, 1, 1, 2, "R4 row miss");
    send(1, 300, 32, 8, 3, 2, 2, "R4 bank miss");
    send(0, 200, 40, 0, 1, 1, 3, "R5 R7 other bank kept");
    send(1, 300, 48, 9, 0, 0, 2, "R7 long length");
    send(2, 5,   1,  7, 0, 0, 3, "R10 zero gaps");
    send(2, 5,   2,  2, 0, 0, 2, "R8 short hit");
    for (int k = 0; k < 60; k++) begin
      send($urandom_range(3), $urandom_range(2), $urandom_range(8191),
           $urandom_range(9), $urandom_range(3), $urandom_range(3),
           2 + $urandom_range(1), "R5 R10 mixed");
    end
    wait (cyc > ready_at + 2);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule